// File: doc/BRIEF.md
# Thread Wake-Up Scoreboard Scheduler

This block keeps a pool of resident shader thread contexts parked while their memory requests are outstanding. It releases each thread to the execution side once all of those requests have returned. Every context owns nine pending bits: bits 0 to 7 stand for texture lookups, and bit 8 stands for an instruction fetch. When the running thread stalls, the execution side reports the stalled thread's ID, the bits it has just made pending, and its saved context record. The record holds a program counter, a clause type, a general-register window base, and a previous-result register set selector.

Completion events carry a thread ID and a slot number, and each one clears a single pending bit. When a waiting thread's last pending bit clears, its ID is appended to an in-order ready queue. The execution side asks for a new thread with a pop request. One cycle later it receives the head thread's ID and stored record, or a not-valid response when nothing can be handed over. Hand-overs are spaced by a minimum switch interval, because the execution unit can change threads only that often.

Top module: `thread_wake_sched`

## Requirements
- R1: After reset every context is free, the queue is empty and `pop_valid` is low, so a pop request issued straight after reset gets a not-valid response.
- R2: An accepted stall stores the thread's record and ORs `stall_pend` into its pending bits. The thread is not queued while any of its pending bits is set.
- R3: A completion with `done_slot` k clears only bit k of the tagged thread (k = 0..7 texture, k = 8 instruction fetch). Slot values 9 to 15 change nothing.
- R4: When a completion clears the last pending bit of a waiting thread, that thread is queued. A later pop returns its ID together with the record stored by its stall.
- R5: A stall that leaves the thread with no pending bits queues the thread directly.
- R6: Threads are popped in the order in which they became ready. When a completion readies one thread and a stall readies another in the same cycle, the completion's thread is queued first.
- R7: A completion and a stall in the same cycle for the same thread are applied completion first. If the completion readies the thread, the thread is queued once and that stall is ignored. Otherwise the stall's bits are added afterwards.
- R8: Accepted pops are at least 4 cycles apart. A pop request made inside that window gets a not-valid response and is not held over.
- R9: A pop request while the queue is empty gets a not-valid response.
- R10: A stall naming a thread that is already queued is ignored: its record and pending bits stay unchanged.
- R11: The queue holds all 128 contexts at once and returns them all, in order, without loss.
- R12: A pop response appears in the cycle after the accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall_valid | input | 1 | A thread is being parked |
| stall_tid | input | 7 | ID of the parked thread |
| stall_pend | input | 9 | Newly pending bits (0-7 texture, 8 instruction fetch) |
| stall_pc | input | 24 | Program counter to resume at |
| stall_clause | input | 2 | Clause type to resume in |
| stall_gpr_base | input | 8 | General-register window base |
| stall_pvsel | input | 2 | Previous-result register set selector |
| done_valid | input | 1 | A memory event has completed |
| done_tid | input | 7 | Thread the completion belongs to |
| done_slot | input | 4 | Pending bit the completion clears |
| pop_req | input | 1 | Execution side asks for the next ready thread |
| pop_valid | output | 1 | A thread is handed over this cycle |
| pop_tid | output | 7 | ID of the handed-over thread |
| pop_pc | output | 24 | Its program counter |
| pop_clause | output | 2 | Its clause type |
| pop_gpr_base | output | 8 | Its register window base |
| pop_pvsel | output | 2 | Its register set selector |

## Verification
The same cycle can carry both a completion and a stall, and the bench provokes this in two ways. In the first, the two events name different threads that both become ready, and the check is that the completion's thread comes out of the queue ahead of the stall's. In the second, they name the same thread. That case is judged in two variants: either the completion frees the thread, so it is popped once with its earlier record and the stall leaves no trace, or it does not, so the stall's bit remains pending and the thread appears only after a further completion.

// File: rtl/swk_pkg.sv
package swk_pkg;
   localparam int PC_W       = 24;
   localparam int CLAUSE_W   = 2;
   localparam int GPR_BASE_W = 8;
   localparam int PVSEL_W    = 2;

   typedef struct packed {
      logic [PC_W-1:0]       pc;
      logic [CLAUSE_W-1:0]   clause;
      logic [GPR_BASE_W-1:0] gpr_base;
      logic [PVSEL_W-1:0]    pvsel;
   } ctx_rec_t;

   typedef enum logic [1:0] {
      CTX_FREE   = 2'd0,
      CTX_WAIT   = 2'd1,
      CTX_QUEUED = 2'd2,
      CTX_RUN    = 2'd3
   } ctx_state_t;
endpackage

// File: rtl/swk_flag_table.sv
module swk_flag_table
   import swk_pkg::*;
#(
   parameter int NUM_CTX = 128,
   parameter int FLAG_W  = 9,
   parameter int SLOT_W  = 4,
   localparam int TID_W  = $clog2(NUM_CTX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done_valid,
   input  logic [TID_W-1:0]  done_tid,
   input  logic [SLOT_W-1:0] done_slot,
   input  logic              stall_valid,
   input  logic [TID_W-1:0]  stall_tid,
   input  logic [FLAG_W-1:0] stall_pend,
   input  logic              pop_fire,
   input  logic [TID_W-1:0]  pop_tid,
   output logic              stall_take,
   output logic              push_a_valid,
   output logic [TID_W-1:0]  push_a_tid,
   output logic              push_b_valid,
   output logic [TID_W-1:0]  push_b_tid
);
   logic [FLAG_W-1:0] flags_rd [NUM_CTX];
   ctx_state_t        st_rd    [NUM_CTX];

   logic [FLAG_W-1:0] done_mask;
   logic [FLAG_W-1:0] d_after;
   logic [FLAG_W-1:0] s_after;
   logic              same_tid;

   always_comb begin
      done_mask = '0;
      if (int'(done_slot) < FLAG_W)
         done_mask = FLAG_W'(1) << done_slot;
      d_after      = flags_rd[done_tid] & ~done_mask;
      same_tid     = done_valid && (done_tid == stall_tid);
      push_a_valid = done_valid && (st_rd[done_tid] == CTX_WAIT) && (d_after == '0);
      stall_take   = stall_valid && (st_rd[stall_tid] != CTX_QUEUED)
                     && !(push_a_valid && same_tid);
      s_after      = (same_tid ? d_after : flags_rd[stall_tid]) | stall_pend;
      push_b_valid = stall_take && (s_after == '0);
   end

   assign push_a_tid = done_tid;
   assign push_b_tid = stall_tid;

   for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
      logic [FLAG_W-1:0] flags_q;
      ctx_state_t        st_q;
      logic              hit_d;
      logic              hit_s;
      logic              hit_p;

      assign hit_d = done_valid && (done_tid == TID_W'(i));
      assign hit_s = stall_take && (stall_tid == TID_W'(i));
      assign hit_p = pop_fire && (pop_tid == TID_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            flags_q <= '0;
            st_q    <= CTX_FREE;
         end else begin
            if (hit_s)
               flags_q <= s_after;
            else if (hit_d)
               flags_q <= d_after;

            if (hit_p)
               st_q <= CTX_RUN;
            else if (hit_s)
               st_q <= push_b_valid ? CTX_QUEUED : CTX_WAIT;
            else if (hit_d && push_a_valid)
               st_q <= CTX_QUEUED;
         end
      end

      assign flags_rd[i] = flags_q;
      assign st_rd[i]    = st_q;
   end
endmodule

// File: rtl/swk_ready_fifo.sv
module swk_ready_fifo #(
   parameter int DEPTH = 128,
   localparam int PTR_W = $clog2(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_a_valid,
   input  logic [PTR_W-1:0] push_a_tid,
   input  logic             push_b_valid,
   input  logic [PTR_W-1:0] push_b_tid,
   input  logic             pop_fire,
   output logic [PTR_W-1:0] head_tid,
   output logic             empty,
   output logic [PTR_W:0]   count
);
   logic [PTR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] b_slot;

   assign b_slot = push_a_valid ? wr_ptr + PTR_W'(1) : wr_ptr;

   always_ff @(posedge clk) begin
      if (push_a_valid)
         mem[wr_ptr] <= push_a_tid;
      if (push_b_valid)
         mem[b_slot] <= push_b_tid;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         wr_ptr <= wr_ptr + PTR_W'(push_a_valid) + PTR_W'(push_b_valid);
         rd_ptr <= rd_ptr + PTR_W'(pop_fire);
         count  <= count + (PTR_W+1)'(push_a_valid) + (PTR_W+1)'(push_b_valid)
                   - (PTR_W+1)'(pop_fire);
      end
   end

   assign head_tid = mem[rd_ptr];
   assign empty    = (count == '0);
endmodule

// File: rtl/swk_ctx_store.sv
module swk_ctx_store
   import swk_pkg::*;
#(
   parameter int NUM_CTX = 128,
   localparam int TID_W  = $clog2(NUM_CTX)
) (
   input  logic             clk,
   input  logic             wr_en,
   input  logic [TID_W-1:0] wr_tid,
   input  ctx_rec_t         wr_rec,
   input  logic [TID_W-1:0] rd_tid,
   output ctx_rec_t         rd_rec
);
   ctx_rec_t mem [NUM_CTX];

   always_ff @(posedge clk) begin
      if (wr_en)
         mem[wr_tid] <= wr_rec;
   end

   assign rd_rec = mem[rd_tid];
endmodule

// File: rtl/swk_switch_pacer.sv
module swk_switch_pacer #(
   parameter int SWITCH_GAP = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pop_req,
   input  logic empty,
   output logic pop_fire
);
   if (SWITCH_GAP > 1) begin : g_paced
      localparam int HW = $clog2(SWITCH_GAP);
      logic [HW-1:0] hold_q;

      assign pop_fire = pop_req && !empty && (hold_q == '0);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            hold_q <= '0;
         else if (pop_fire)
            hold_q <= HW'(SWITCH_GAP - 1);
         else if (hold_q != '0)
            hold_q <= hold_q - HW'(1);
      end
   end else begin : g_free
      assign pop_fire = pop_req && !empty;
   end
endmodule

// File: rtl/thread_wake_sched.sv
module thread_wake_sched
   import swk_pkg::*;
#(
   parameter int NUM_CTX    = 128,
   parameter int TEX_SLOTS  = 8,
   parameter int SWITCH_GAP = 4,
   localparam int TID_W     = $clog2(NUM_CTX),
   localparam int FLAG_W    = TEX_SLOTS + 1,
   localparam int SLOT_W    = $clog2(FLAG_W)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  stall_valid,
   input  logic [TID_W-1:0]      stall_tid,
   input  logic [FLAG_W-1:0]     stall_pend,
   input  logic [PC_W-1:0]       stall_pc,
   input  logic [CLAUSE_W-1:0]   stall_clause,
   input  logic [GPR_BASE_W-1:0] stall_gpr_base,
   input  logic [PVSEL_W-1:0]    stall_pvsel,
   input  logic                  done_valid,
   input  logic [TID_W-1:0]      done_tid,
   input  logic [SLOT_W-1:0]     done_slot,
   input  logic                  pop_req,
   output logic                  pop_valid,
   output logic [TID_W-1:0]      pop_tid,
   output logic [PC_W-1:0]       pop_pc,
   output logic [CLAUSE_W-1:0]   pop_clause,
   output logic [GPR_BASE_W-1:0] pop_gpr_base,
   output logic [PVSEL_W-1:0]    pop_pvsel
);
   if (NUM_CTX < 2 || (NUM_CTX & (NUM_CTX - 1)) != 0) begin : g_bad_ctx
      $error("thread_wake_sched: NUM_CTX must be a power of two of at least 2");
   end
   if (TEX_SLOTS < 1 || TEX_SLOTS > 15) begin : g_bad_slots
      $error("thread_wake_sched: TEX_SLOTS must lie in 1..15");
   end
   if (SWITCH_GAP < 1) begin : g_bad_gap
      $error("thread_wake_sched: SWITCH_GAP must be at least 1");
   end

   logic             stall_take;
   logic             push_a_valid;
   logic [TID_W-1:0] push_a_tid;
   logic             push_b_valid;
   logic [TID_W-1:0] push_b_tid;
   logic             pop_fire;
   logic [TID_W-1:0] head_tid;
   logic             q_empty;
   logic [TID_W:0]   q_count;
   ctx_rec_t         stall_rec;
   ctx_rec_t         head_rec;

   assign stall_rec = '{pc: stall_pc, clause: stall_clause,
                        gpr_base: stall_gpr_base, pvsel: stall_pvsel};

   swk_flag_table #(.NUM_CTX(NUM_CTX), .FLAG_W(FLAG_W), .SLOT_W(SLOT_W)) u_flags (
      .clk          (clk),
      .rst_n        (rst_n),
      .done_valid   (done_valid),
      .done_tid     (done_tid),
      .done_slot    (done_slot),
      .stall_valid  (stall_valid),
      .stall_tid    (stall_tid),
      .stall_pend   (stall_pend),
      .pop_fire     (pop_fire),
      .pop_tid      (head_tid),
      .stall_take   (stall_take),
      .push_a_valid (push_a_valid),
      .push_a_tid   (push_a_tid),
      .push_b_valid (push_b_valid),
      .push_b_tid   (push_b_tid)
   );

   swk_ready_fifo #(.DEPTH(NUM_CTX)) u_queue (
      .clk          (clk),
      .rst_n        (rst_n),
      .push_a_valid (push_a_valid),
      .push_a_tid   (push_a_tid),
      .push_b_valid (push_b_valid),
      .push_b_tid   (push_b_tid),
      .pop_fire     (pop_fire),
      .head_tid     (head_tid),
      .empty        (q_empty),
      .count        (q_count)
   );

   swk_ctx_store #(.NUM_CTX(NUM_CTX)) u_ctx (
      .clk    (clk),
      .wr_en  (stall_take),
      .wr_tid (stall_tid),
      .wr_rec (stall_rec),
      .rd_tid (head_tid),
      .rd_rec (head_rec)
   );

   swk_switch_pacer #(.SWITCH_GAP(SWITCH_GAP)) u_pacer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pop_req  (pop_req),
      .empty    (q_empty),
      .pop_fire (pop_fire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pop_valid    <= 1'b0;
         pop_tid      <= '0;
         pop_pc       <= '0;
         pop_clause   <= '0;
         pop_gpr_base <= '0;
         pop_pvsel    <= '0;
      end else begin
         pop_valid <= pop_fire;
         if (pop_fire) begin
            pop_tid      <= head_tid;
            pop_pc       <= head_rec.pc;
            pop_clause   <= head_rec.clause;
            pop_gpr_base <= head_rec.gpr_base;
            pop_pvsel    <= head_rec.pvsel;
         end
      end
   end
endmodule

// File: rtl/swk_checker.sv
module swk_checker #(
   parameter int NUM_CTX    = 128,
   parameter int SWITCH_GAP = 4,
   localparam int TID_W     = $clog2(NUM_CTX),
   localparam int GW        = $clog2(SWITCH_GAP + 1) + 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pop_req,
   input logic             pop_valid,
   input logic [TID_W:0]   q_count,
   input logic             push_a_valid,
   input logic [TID_W-1:0] push_a_tid,
   input logic             push_b_valid,
   input logic [TID_W-1:0] push_b_tid
);
   logic [GW-1:0] since_pop;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         since_pop <= GW'(SWITCH_GAP);
      else if (pop_valid)
         since_pop <= GW'(1);
      else if (int'(since_pop) < SWITCH_GAP)
         since_pop <= since_pop + GW'(1);
   end

   assert_pop_spacing_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> int'(since_pop) >= SWITCH_GAP);

   assert_pop_after_req_R12: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> $past(pop_req));

   assert_no_pop_when_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      pop_valid |-> $past(q_count) != '0);

   assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= NUM_CTX);

   assert_single_enqueue_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push_a_valid && push_b_valid) |-> push_a_tid != push_b_tid);

   assert_queue_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      int'(q_count) <= int'($past(q_count)) + 2);
endmodule

bind thread_wake_sched swk_checker #(.NUM_CTX(NUM_CTX), .SWITCH_GAP(SWITCH_GAP)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .pop_req      (pop_req),
   .pop_valid    (pop_valid),
   .q_count      (q_count),
   .push_a_valid (push_a_valid),
   .push_a_tid   (push_a_tid),
   .push_b_valid (push_b_valid),
   .push_b_tid   (push_b_tid)
);

// File: tb/thread_wake_sched_test.sv
module thread_wake_sched_test;
   import swk_pkg::*;

   localparam int N   = 128;
   localparam int GAP = 4;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  stall_valid = 1'b0;
   logic [6:0]            stall_tid = '0;
   logic [8:0]            stall_pend = '0;
   logic [PC_W-1:0]       stall_pc = '0;
   logic [CLAUSE_W-1:0]   stall_clause = '0;
   logic [GPR_BASE_W-1:0] stall_gpr_base = '0;
   logic [PVSEL_W-1:0]    stall_pvsel = '0;
   logic                  done_valid = 1'b0;
   logic [6:0]            done_tid = '0;
   logic [3:0]            done_slot = '0;
   logic                  pop_req = 1'b0;
   logic                  pop_valid;
   logic [6:0]            pop_tid;
   logic [PC_W-1:0]       pop_pc;
   logic [CLAUSE_W-1:0]   pop_clause;
   logic [GPR_BASE_W-1:0] pop_gpr_base;
   logic [PVSEL_W-1:0]    pop_pvsel;

   thread_wake_sched uut (
      .clk(clk), .rst_n(rst_n),
      .stall_valid(stall_valid), .stall_tid(stall_tid), .stall_pend(stall_pend),
      .stall_pc(stall_pc), .stall_clause(stall_clause),
      .stall_gpr_base(stall_gpr_base), .stall_pvsel(stall_pvsel),
      .done_valid(done_valid), .done_tid(done_tid), .done_slot(done_slot),
      .pop_req(pop_req), .pop_valid(pop_valid), .pop_tid(pop_tid), .pop_pc(pop_pc),
      .pop_clause(pop_clause), .pop_gpr_base(pop_gpr_base), .pop_pvsel(pop_pvsel)
   );

   always #4 clk = ~clk;

   typedef struct {
      int       tid;
      ctx_rec_t rec;
   } ready_t;

   typedef struct {
      int       cyc;
      bit       want;
      int       tid;
      ctx_rec_t rec;
      string    req;
   } due_t;

   int       tests = 0;
   int       fails = 0;
   int       cyc = 0;
   int       last_fire = -100;
   bit       finished = 1'b0;
   logic [8:0] m_flags [N];
   int       m_st [N];
   ctx_rec_t m_rec [N];
   ready_t   exp_q [$];
   due_t     due_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic ctx_rec_t mk(int tid, int salt);
      ctx_rec_t r;
      r.pc       = PC_W'(tid * 4096 + salt * 16 + 3);
      r.clause   = CLAUSE_W'(salt);
      r.gpr_base = GPR_BASE_W'(tid + salt * 7);
      r.pvsel    = PVSEL_W'(tid + salt);
      return r;
   endfunction

   task automatic check(bit ok, string req, string what, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic model_enq(int t);
      ready_t e;
      m_st[t] = 2;
      e.tid = t;
      e.rec = m_rec[t];
      exp_q.push_back(e);
   endtask

   task automatic model_done(int t, int slot);
      if (slot < 9) m_flags[t][slot] = 1'b0;
      if (m_st[t] == 1 && m_flags[t] == '0) model_enq(t);
   endtask

   task automatic model_stall(int t, logic [8:0] m, ctx_rec_t r);
      if (m_st[t] == 2) return;
      m_flags[t] = m_flags[t] | m;
      m_rec[t] = r;
      if (m_flags[t] == '0) model_enq(t);
      else m_st[t] = 1;
   endtask

   // Driver: one cycle of stimulus, with the expectation logged on the scoreboard.
   task automatic step(bit dv, int dt, int ds, bit sv, int st, logic [8:0] sm,
                       ctx_rec_t sr, bit pr, string req);
      due_t   d;
      ready_t e;
      bit     want;
      @(negedge clk);
      done_valid = dv; done_tid = 7'(dt); done_slot = 4'(ds);
      stall_valid = sv; stall_tid = 7'(st); stall_pend = sm;
      stall_pc = sr.pc; stall_clause = sr.clause;
      stall_gpr_base = sr.gpr_base; stall_pvsel = sr.pvsel;
      pop_req = pr;
      want = 1'b0;
      if (pr) begin
         want = (exp_q.size() > 0) && ((cyc + 1 - last_fire) >= GAP);
         d.cyc = cyc + 1; d.want = want; d.req = req; d.tid = 0; d.rec = '0;
         if (want) begin
            e = exp_q.pop_front();
            d.tid = e.tid; d.rec = e.rec;
            last_fire = cyc + 1;
         end
         due_q.push_back(d);
      end
      if (dv) model_done(dt, ds);
      if (sv) model_stall(st, sm, sr);
      if (want) m_st[d.tid] = 3;
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, '0, '0, 0, "");
   endtask

   task automatic stall(int t, logic [8:0] m, int salt, string req);
      step(0, 0, 0, 1, t, m, mk(t, salt), 0, req);
   endtask

   task automatic done(int t, int slot, string req);
      step(1, t, slot, 0, 0, '0, '0, 0, req);
   endtask

   task automatic pop(string req);
      step(0, 0, 0, 0, 0, '0, '0, 1, req);
   endtask

   task automatic spaced_pop(string req);
      idle(GAP);
      pop(req);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      for (int i = 0; i < N; i++) begin
         m_flags[i] = '0; m_st[i] = 0; m_rec[i] = '0;
      end
      exp_q.delete();
      due_q.delete();
      last_fire = -100;
      repeat (3) @(negedge clk);
      check(pop_valid == 1'b0, "R1", "pop_valid in reset", int'(pop_valid), 0);
      rst_n = 1'b1;
   endtask

   // Monitor: compares every scheduled pop response against the scoreboard.
   always @(negedge clk) begin
      if (rst_n) begin
         if (due_q.size() > 0 && due_q[0].cyc == cyc) begin
            due_t d;
            d = due_q.pop_front();
            check(pop_valid == d.want, d.req, "pop_valid", int'(pop_valid), int'(d.want));
            if (d.want && pop_valid) begin
               check(int'(pop_tid) == d.tid, d.req, "pop_tid", int'(pop_tid), d.tid);
               check(pop_pc == d.rec.pc && pop_clause == d.rec.clause &&
                     pop_gpr_base == d.rec.gpr_base && pop_pvsel == d.rec.pvsel,
                     d.req, "record pc", int'(pop_pc), int'(d.rec.pc));
            end
         end else if (pop_valid) begin
            check(1'b0, "R12", "unrequested pop_valid", 1, 0);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         fails++;
         $display("FAIL watchdog: run hung, actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 / R9: empty queue right after reset
      pop("R1");
      pop("R9");

      // R2 / R3 / R4: two texture bits pending
      stall(5, 9'h003, 1, "R2");
      pop("R2");
      done(5, 0, "R3");
      pop("R2");
      done(5, 12, "R3");
      pop("R3");
      done(5, 1, "R4");
      spaced_pop("R4");

      // R3: instruction-fetch bit 8, wrong slot has no effect
      stall(6, 9'h100, 2, "R3");
      done(6, 7, "R3");
      spaced_pop("R3");
      done(6, 8, "R3");
      spaced_pop("R3");

      // R5: nothing pending at stall
      stall(7, 9'h000, 3, "R5");
      spaced_pop("R5");

      // R6: ordering by readiness
      stall(10, 9'h100, 1, "R6");
      stall(11, 9'h100, 2, "R6");
      stall(12, 9'h000, 3, "R6");
      done(11, 8, "R6");
      done(10, 8, "R6");
      spaced_pop("R6");
      spaced_pop("R6");
      spaced_pop("R6");
      // R6: completion and stall ready different threads in one cycle
      stall(20, 9'h004, 1, "R6");
      step(1, 20, 2, 1, 21, 9'h000, mk(21, 2), 0, "R6");
      spaced_pop("R6");
      spaced_pop("R6");

      // R7: same thread, completion frees it, stall ignored
      stall(30, 9'h001, 1, "R7");
      step(1, 30, 0, 1, 30, 9'h002, mk(30, 2), 0, "R7");
      spaced_pop("R7");
      spaced_pop("R7");
      // R7: same thread, completion does not free it, stall bits kept
      step(1, 31, 0, 1, 31, 9'h001, mk(31, 1), 0, "R7");
      spaced_pop("R7");
      done(31, 0, "R7");
      spaced_pop("R7");

      // R10: stall to a queued thread is ignored
      stall(40, 9'h000, 1, "R10");
      stall(40, 9'h001, 2, "R10");
      spaced_pop("R10");
      spaced_pop("R10");

      // R8: back-to-back pop requests
      stall(50, 9'h000, 1, "R8");
      stall(51, 9'h000, 2, "R8");
      idle(GAP);
      for (int i = 0; i < 6; i++) pop("R8");
      idle(2);

      // R11: every context queued at once
      do_reset();
      for (int t = 0; t < N; t++) stall(t, 9'h000, 5, "R11");
      for (int t = 0; t < N; t++) spaced_pop("R11");
      spaced_pop("R11");
      idle(3);

      check(due_q.size() == 0, "R12", "pending responses", due_q.size(), 0);
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule